// File: doc/BRIEF.md
# DSP Accumulator Writeback and Status Flags

This block is the writeback stage of a fixed-point DSP data path. It takes a 32-bit product, scales it by one of four alignment factors picked from a control register, and forms a load, add or subtract result into one of two 36-bit accumulators. A fourth operation loads only the upper 16 bits of an accumulator from a separate half-word input.

Results that overflow 32 bits can be clamped to the largest positive or negative 32-bit value. Clamping can be turned off for each accumulator on its own. After every operation a 16-bit status word records four things about the value written: whether it is zero, whether it is negative, whether it overflowed 32 bits, and whether the exact result overflowed 36 bits. Software reads and writes both the control register and the status word, always as whole 16-bit values.

The multiplier, the shifter, instruction decode and the pseudorandom generator sit outside the block. Control bits that only those units use are stored and read back, and nothing more.

Top module: `dsp_acc_wb`

## Requirements
- R1: The control register resets to 0 and is loaded with the full `ctl_wdata` when `ctl_we` is 1. Bits [15:9] always read as 0. A write takes effect from the next cycle, so an operation issued in the same cycle uses the old value.
- R2: The product is sign-extended to 36 bits and then aligned by control bits [1:0]. The codes are 00 unchanged, 01 arithmetic shift right by 2, 10 multiply by 4 and 11 multiply by 2; a left shift fills the low bits with zeros.
- R3: `op_sel` selects the operation: 1 load (acc = aligned p), 2 add (acc + aligned p), 3 subtract (acc - aligned p) and 4 load high half. The codes 0, 5, 6 and 7 change nothing. `dst_sel` 0 targets a0 and 1 targets a1. The other accumulator is left as it was, and the result is visible one cycle after the operation.
- R4: A 32-bit overflow occurs when result bits [35:31] are not all equal. If saturation is enabled, the accumulator receives 0x0_7FFF_FFFF when the exact result is positive and 0xF_8000_0000 when it is negative. Saturation is enabled when the accumulator's disable bit is 0: control bit 2 for a0, bit 3 for a1. With the disable bit set, the wrapped 36-bit result is written.
- R5: Load high half writes `hi_in` to bits [31:16] and its sign to bits [35:32]. The low 16 bits are cleared, unless the keep bit for that accumulator is 1, in which case they are kept. The keep bit is control bit 4 for a0 and bit 5 for a1.
- R6: Status bit 9 (a0) or bit 4 (a1) of the target accumulator is set to that operation's 32-bit overflow, judged before saturation. The bit of the other accumulator is left unchanged.
- R7: Status bit 13 is set when the exact result of an operation does not fit in 36 signed bits, and is cleared by any operation whose result fits.
- R8: Status bit 14 is set when the value written is zero in all 36 bits. Status bit 15 is set to bit 35 of the value written.
- R9: The status word resets to 0. When `sw_we` is 1 it takes `sw_wdata` in full, and this write has priority over a flag update in the same cycle. Operations leave status bits other than 15, 14, 13, 9 and 4 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 3 | Operation code |
| dst_sel | input | 1 | Target accumulator (0 = a0, 1 = a1) |
| p_in | input | 32 | Product value |
| hi_in | input | 16 | Half-word for load high half |
| ctl_we | input | 1 | Control register write enable |
| ctl_wdata | input | 16 | Control register write data |
| ctl_rdata | output | 16 | Control register read value |
| sw_we | input | 1 | Status word write enable |
| sw_wdata | input | 16 | Status word write data |
| sw_rdata | output | 16 | Status word read value |
| a0_out | output | 36 | Accumulator a0 |
| a1_out | output | 36 | Accumulator a1 |

## Verification
The hardest state to reach is the 36-bit logical overflow. A single load can never produce it, and as long as saturation is on the accumulator is clamped back into 32 bits first. The stimulus therefore turns off saturation for a1 only and selects the multiply-by-4 alignment. It loads a1 with four times the largest positive product and adds the same value repeatedly: the fourth add is the first whose exact sum exceeds the 36-bit range. A reference model checks every cycle, and random traffic then mixes operations, alignments and register writes.

// File: rtl/dsp_acc_pkg.sv
package dsp_acc_pkg;

    localparam int PW   = 32;
    localparam int AW   = 36;
    localparam int HW   = 16;
    localparam int RW   = 16;
    localparam int NACC = 2;
    localparam int DW   = $clog2(NACC);

    localparam int SW_NEG  = 15;
    localparam int SW_ZERO = 14;
    localparam int SW_LOV  = 13;
    localparam int SW_OV0  = 9;
    localparam int SW_OV1  = 4;

    localparam logic [RW-1:0] CTL_MASK = 16'h01FF;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LOAD = 3'd1,
        OP_ADD  = 3'd2,
        OP_SUB  = 3'd3,
        OP_LDHI = 3'd4
    } acc_op_e;

    typedef struct packed {
        logic [6:0] rsv;
        logic       rnd_mode;
        logic       sq_mode;
        logic       y_keep;
        logic       a1_keep;
        logic       a0_keep;
        logic       a1_nosat;
        logic       a0_nosat;
        logic [1:0] align;
    } ctl_t;

    typedef struct packed {
        logic [AW-1:0] value;
        logic          math_ovf;
        logic          logic_ovf;
    } wb_res_t;

    function automatic logic [AW-1:0] sat_value(input logic neg);
        if (neg) return {{(AW-PW+1){1'b1}}, {(PW-1){1'b0}}};
        return {{(AW-PW+1){1'b0}}, {(PW-1){1'b1}}};
    endfunction

endpackage

// File: rtl/dsp_acc_align.sv
module dsp_acc_align
    import dsp_acc_pkg::*;
(
    input  logic [1:0]    mode,
    input  logic [PW-1:0] prod,
    output logic [AW-1:0] aligned
);
    logic [AW-1:0] ext;

    always_comb begin
        ext = {{(AW-PW){prod[PW-1]}}, prod};
        unique case (mode)
            2'b00:   aligned = ext;
            2'b01:   aligned = AW'($signed(ext) >>> 2);
            2'b10:   aligned = ext << 2;
            default: aligned = ext << 1;
        endcase
    end
endmodule

// File: rtl/dsp_acc_arith.sv
module dsp_acc_arith
    import dsp_acc_pkg::*;
(
    input  acc_op_e       op,
    input  logic [AW-1:0] acc,
    input  logic [AW-1:0] aligned,
    input  logic [HW-1:0] hi,
    input  logic          keep_low,
    input  logic          sat_off,
    output wb_res_t       res
);
    logic [AW:0]   lhs;
    logic [AW:0]   rhs;
    logic [AW:0]   sum;
    logic [AW-1:0] wide;
    logic          mov;

    always_comb begin
        lhs  = (op == OP_LOAD) ? '0 : {acc[AW-1], acc};
        rhs  = {aligned[AW-1], aligned};
        sum  = (op == OP_SUB) ? (lhs - rhs) : (lhs + rhs);
        wide = sum[AW-1:0];
        mov  = (|wide[AW-1:PW-1]) && !(&wide[AW-1:PW-1]);
        if (op == OP_LDHI) begin
            res.value     = {{(AW-PW){hi[HW-1]}}, hi,
                             keep_low ? acc[PW-HW-1:0] : {(PW-HW){1'b0}}};
            res.math_ovf  = 1'b0;
            res.logic_ovf = 1'b0;
        end else begin
            res.value     = (mov && !sat_off) ? sat_value(sum[AW]) : wide;
            res.math_ovf  = mov;
            res.logic_ovf = sum[AW] ^ sum[AW-1];
        end
    end
endmodule

// File: rtl/dsp_acc_status.sv
module dsp_acc_status
    import dsp_acc_pkg::*;
(
    input  logic [RW-1:0] cur,
    input  logic          fire,
    input  logic [DW-1:0] dst,
    input  wb_res_t       res,
    input  logic          sw_we,
    input  logic [RW-1:0] sw_wdata,
    output logic [RW-1:0] nxt
);
    always_comb begin
        nxt = cur;
        if (fire) begin
            nxt[SW_NEG]  = res.value[AW-1];
            nxt[SW_ZERO] = (res.value == '0);
            nxt[SW_LOV]  = res.logic_ovf;
            if (dst == DW'(1)) nxt[SW_OV1] = res.math_ovf;
            else               nxt[SW_OV0] = res.math_ovf;
        end
        if (sw_we) nxt = sw_wdata;
    end
endmodule

// File: rtl/dsp_acc_wb.sv
module dsp_acc_wb
    import dsp_acc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    op_sel,
    input  logic          dst_sel,
    input  logic [31:0]   p_in,
    input  logic [15:0]   hi_in,
    input  logic          ctl_we,
    input  logic [15:0]   ctl_wdata,
    output logic [15:0]   ctl_rdata,
    input  logic          sw_we,
    input  logic [15:0]   sw_wdata,
    output logic [15:0]   sw_rdata,
    output logic [35:0]   a0_out,
    output logic [35:0]   a1_out
);
    ctl_t          ctl_q;
    logic [RW-1:0] sw_q;
    logic [RW-1:0] sw_nxt;
    logic [AW-1:0] acc_q [NACC];
    logic [AW-1:0] aligned;
    logic [AW-1:0] acc_sel;
    acc_op_e       op;
    logic          fire;
    logic [NACC-1:0] keep_bits;
    logic [NACC-1:0] nosat_bits;
    wb_res_t       res;

    assign op         = acc_op_e'(op_sel);
    assign fire       = (op == OP_LOAD) || (op == OP_ADD) ||
                        (op == OP_SUB)  || (op == OP_LDHI);
    assign acc_sel    = acc_q[dst_sel];
    assign keep_bits  = {ctl_q.a1_keep, ctl_q.a0_keep};
    assign nosat_bits = {ctl_q.a1_nosat, ctl_q.a0_nosat};

    dsp_acc_align u_align (
        .mode    (ctl_q.align),
        .prod    (p_in),
        .aligned (aligned)
    );

    dsp_acc_arith u_arith (
        .op       (op),
        .acc      (acc_sel),
        .aligned  (aligned),
        .hi       (hi_in),
        .keep_low (keep_bits[dst_sel]),
        .sat_off  (nosat_bits[dst_sel]),
        .res      (res)
    );

    dsp_acc_status u_status (
        .cur      (sw_q),
        .fire     (fire),
        .dst      (dst_sel),
        .res      (res),
        .sw_we    (sw_we),
        .sw_wdata (sw_wdata),
        .nxt      (sw_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            sw_q  <= '0;
        end else begin
            if (ctl_we) ctl_q <= ctl_t'(ctl_wdata & CTL_MASK);
            sw_q <= sw_nxt;
        end
    end

    for (genvar i = 0; i < NACC; i++) begin : g_acc
        always_ff @(posedge clk) begin
            if (rst)                                  acc_q[i] <= '0;
            else if (fire && (dst_sel == DW'(i)))     acc_q[i] <= res.value;
        end
    end

    assign ctl_rdata = ctl_q;
    assign sw_rdata  = sw_q;
    assign a0_out    = acc_q[0];
    assign a1_out    = acc_q[1];
endmodule

// File: rtl/dsp_acc_wb_chk.sv
module dsp_acc_wb_chk (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  op_sel,
    input logic        dst_sel,
    input logic        sw_we,
    input logic [15:0] ctl_rdata,
    input logic [15:0] sw_rdata,
    input logic [35:0] a0_out,
    input logic [35:0] a1_out
);
    logic fire;
    assign fire = (op_sel >= 3'd1) && (op_sel <= 3'd4);

    // R1
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[15:9] == 7'd0);

    // R3
    a_r3_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !fire |=> ($stable(a0_out) && $stable(a1_out)));

    a_r3_other_acc: assert property (@(posedge clk) disable iff (rst)
        (fire && !dst_sel) |=> $stable(a1_out));

    // R4
    a_r4_a0_clamped: assert property (@(posedge clk) disable iff (rst)
        (fire && !dst_sel && !ctl_rdata[2]) |=>
        ((a0_out[35:31] == 5'b00000) || (a0_out[35:31] == 5'b11111)));

    a_r4_a1_clamped: assert property (@(posedge clk) disable iff (rst)
        (fire && dst_sel && !ctl_rdata[3]) |=>
        ((a1_out[35:31] == 5'b00000) || (a1_out[35:31] == 5'b11111)));

    // R8
    a_r8_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (fire && !sw_we) |=>
        (sw_rdata[14] == ($past(dst_sel) ? (a1_out == 36'd0) : (a0_out == 36'd0))));

    a_r8_neg_flag: assert property (@(posedge clk) disable iff (rst)
        (fire && !sw_we) |=>
        (sw_rdata[15] == ($past(dst_sel) ? a1_out[35] : a0_out[35])));

    // R9
    a_r9_spare_bits: assert property (@(posedge clk) disable iff (rst)
        (fire && !sw_we) |=> (sw_rdata[12:10] == $past(sw_rdata[12:10])));
endmodule

bind dsp_acc_wb dsp_acc_wb_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .op_sel    (op_sel),
    .dst_sel   (dst_sel),
    .sw_we     (sw_we),
    .ctl_rdata (ctl_rdata),
    .sw_rdata  (sw_rdata),
    .a0_out    (a0_out),
    .a1_out    (a1_out)
);

// File: tb/dsp_acc_wb_bench.sv
module dsp_acc_wb_bench;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG_CYCLES = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_sel = '0;
    logic        dst_sel = 1'b0;
    logic [31:0] p_in = '0;
    logic [15:0] hi_in = '0;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic        sw_we = 1'b0;
    logic [15:0] sw_wdata = '0;
    logic [15:0] sw_rdata;
    logic [35:0] a0_out;
    logic [35:0] a1_out;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    longint      m_a [2];
    logic [15:0] m_ctl;
    logic [15:0] m_sw;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsp_acc_wb u_dsp_acc_wb (
        .clk(clk), .rst(rst), .op_sel(op_sel), .dst_sel(dst_sel),
        .p_in(p_in), .hi_in(hi_in), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .sw_we(sw_we), .sw_wdata(sw_wdata),
        .sw_rdata(sw_rdata), .a0_out(a0_out), .a1_out(a1_out)
    );

    function automatic longint wrap36(input longint t);
        longint u;
        u = t & 64'h0000_000F_FFFF_FFFF;
        if (u[35]) u = u - 64'h0000_0010_0000_0000;
        return u;
    endfunction

    // Behavioural reference model, updated at each rising edge.
    always @(posedge clk) begin
        if (rst) begin
            m_ctl = '0; m_sw = '0; m_a[0] = 0; m_a[1] = 0;
        end else begin
            longint pv, al, t, w, cur;
            int d;
            bit fire, mov, lov;
            logic [15:0] nsw;
            d   = dst_sel ? 1 : 0;
            cur = m_a[d];
            pv  = longint'($signed(p_in));
            case (m_ctl[1:0])
                2'b00: al = pv;
                2'b01: al = pv >>> 2;
                2'b10: al = pv * 4;
                default: al = pv * 2;
            endcase
            fire = 1'b1;
            t = 0;
            case (op_sel)
                3'd1: t = al;
                3'd2: t = cur + al;
                3'd3: t = cur - al;
                3'd4: t = longint'($signed(hi_in)) * 65536 +
                          (m_ctl[4+d] ? (cur & 64'hFFFF) : 0);
                default: fire = 1'b0;
            endcase
            lov = (t > 64'sd34359738367) || (t < -64'sd34359738368);
            w   = wrap36(t);
            mov = (w > 64'sd2147483647) || (w < -64'sd2147483648);
            if (mov && !m_ctl[2+d]) w = (t < 0) ? -64'sd2147483648 : 64'sd2147483647;
            nsw = m_sw;
            if (fire) begin
                nsw[15] = (w < 0);
                nsw[14] = (w == 0);
                nsw[13] = lov;
                if (d == 1) nsw[4] = mov; else nsw[9] = mov;
                m_a[d] = w;
            end
            if (sw_we) nsw = sw_wdata;
            m_sw = nsw;
            if (ctl_we) m_ctl = {7'd0, ctl_wdata[8:0]};
        end
    end

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Compare against the model on every cycle, away from the rising edge.
    always @(negedge clk) begin
        if (checking && !done) begin
            check(cur_tag, "ctl_rdata", 64'(ctl_rdata), 64'(m_ctl));
            check(cur_tag, "sw_rdata",  64'(sw_rdata),  64'(m_sw));
            check(cur_tag, "a0_out",    64'(a0_out),    64'(m_a[0][35:0]));
            check(cur_tag, "a1_out",    64'(a1_out),    64'(m_a[1][35:0]));
        end
    end

    task automatic step(input logic [2:0] o, input logic d, input logic [31:0] p,
                        input logic [15:0] h, input logic cwe, input logic [15:0] cw,
                        input logic swe, input logic [15:0] sww);
        op_sel = o; dst_sel = d; p_in = p; hi_in = h;
        ctl_we = cwe; ctl_wdata = cw; sw_we = swe; sw_wdata = sww;
        @(negedge clk);
        op_sel = '0; ctl_we = 1'b0; sw_we = 1'b0;
    endtask

    task automatic wr_ctl(input logic [15:0] v);
        step(3'd0, 1'b0, 32'd0, 16'd0, 1'b1, v, 1'b0, 16'd0);
    endtask

    task automatic do_op(input logic [2:0] o, input logic d, input logic [31:0] p,
                         input logic [15:0] h);
        step(o, d, p, h, 1'b0, 16'd0, 1'b0, 16'd0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        checking = 1'b1;

        cur_tag = "R1";
        check("R1", "reset ctl", 64'(ctl_rdata), 64'h0);
        check("R9", "reset sw", 64'(sw_rdata), 64'h0);
        wr_ctl(16'hFFFF);
        check("R1", "upper bits zero", 64'(ctl_rdata), 64'h01FF);
        wr_ctl(16'h0000);

        cur_tag = "R2";
        do_op(3'd1, 1'b0, 32'h10, 16'h0);
        check("R2", "align 00", 64'(a0_out), 64'h10);
        wr_ctl(16'h0001); do_op(3'd1, 1'b0, 32'h10, 16'h0);
        check("R2", "align 01", 64'(a0_out), 64'h4);
        do_op(3'd1, 1'b0, 32'hFFFF_FFFD, 16'h0);
        check("R2", "align 01 negative", 64'(a0_out), 64'hF_FFFF_FFFF);
        wr_ctl(16'h0002); do_op(3'd1, 1'b0, 32'h10, 16'h0);
        check("R2", "align 10", 64'(a0_out), 64'h40);
        wr_ctl(16'h0003); do_op(3'd1, 1'b0, 32'h10, 16'h0);
        check("R2", "align 11", 64'(a0_out), 64'h20);

        cur_tag = "R3";
        wr_ctl(16'h0000);
        do_op(3'd2, 1'b0, 32'h5, 16'h0);
        check("R3", "add", 64'(a0_out), 64'h25);
        do_op(3'd3, 1'b0, 32'h30, 16'h0);
        check("R3", "sub", 64'(a0_out), 64'hF_FFFF_FFF5);
        check("R8", "negative flag", 64'(sw_rdata[15]), 64'h1);
        check("R3", "a1 untouched", 64'(a1_out), 64'h0);
        do_op(3'd1, 1'b0, 32'h7, 16'h0);
        do_op(3'd3, 1'b0, 32'h7, 16'h0);
        check("R8", "zero flag", 64'(sw_rdata[14]), 64'h1);
        for (int c = 5; c <= 8; c++) begin
            do_op(3'(c % 8), 1'b0, 32'h1234, 16'h1);
            check("R3", "no-op leaves a0", 64'(a0_out), 64'h0);
        end

        cur_tag = "R4";
        wr_ctl(16'h0002);
        do_op(3'd1, 1'b0, 32'h4000_0000, 16'h0);
        check("R4", "positive clamp", 64'(a0_out), 64'h0_7FFF_FFFF);
        check("R6", "a0 ovf bit9", 64'(sw_rdata[9]), 64'h1);
        do_op(3'd1, 1'b1, 32'hC000_0000, 16'h0);
        check("R4", "negative clamp", 64'(a1_out), 64'hF_8000_0000);
        check("R6", "a1 ovf bit4", 64'(sw_rdata[4]), 64'h1);
        wr_ctl(16'h0006);
        do_op(3'd1, 1'b0, 32'h4000_0000, 16'h0);
        check("R4", "sat disabled wraps", 64'(a0_out), 64'h1_0000_0000);
        cur_tag = "R6";
        do_op(3'd1, 1'b0, 32'h1, 16'h0);
        check("R6", "a0 ovf cleared", 64'(sw_rdata[9]), 64'h0);
        check("R6", "a1 ovf kept", 64'(sw_rdata[4]), 64'h1);

        cur_tag = "R7";
        wr_ctl(16'h000A);
        do_op(3'd1, 1'b1, 32'h7FFF_FFFF, 16'h0);
        for (int k = 0; k < 3; k++) do_op(3'd2, 1'b1, 32'h7FFF_FFFF, 16'h0);
        check("R7", "no logical ovf yet", 64'(sw_rdata[13]), 64'h0);
        do_op(3'd2, 1'b1, 32'h7FFF_FFFF, 16'h0);
        check("R7", "logical ovf set", 64'(sw_rdata[13]), 64'h1);
        check("R7", "wrapped value", 64'(a1_out), 64'h9_FFFF_FFEC);
        do_op(3'd1, 1'b1, 32'h1, 16'h0);
        check("R7", "logical ovf cleared", 64'(sw_rdata[13]), 64'h0);

        cur_tag = "R5";
        wr_ctl(16'h0000);
        do_op(3'd1, 1'b0, 32'h1234_5678, 16'h0);
        do_op(3'd4, 1'b0, 32'h0, 16'hABCD);
        check("R5", "high load clears low", 64'(a0_out), 64'hF_ABCD_0000);
        do_op(3'd1, 1'b0, 32'h1234_5678, 16'h0);
        wr_ctl(16'h0010);
        do_op(3'd4, 1'b0, 32'h0, 16'h1111);
        check("R5", "high load keeps low", 64'(a0_out), 64'h0_1111_5678);

        cur_tag = "R9";
        step(3'd0, 1'b0, 32'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'hA5A5);
        check("R9", "status write", 64'(sw_rdata), 64'hA5A5);
        step(3'd1, 1'b0, 32'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h0000);
        check("R9", "write beats flags", 64'(sw_rdata), 64'h0);
        step(3'd0, 1'b0, 32'h0, 16'h0, 1'b0, 16'h0, 1'b1, 16'h1C00);
        do_op(3'd1, 1'b0, 32'h3, 16'h0);
        check("R9", "spare bits kept", 64'(sw_rdata[12:10]), 64'h7);

        cur_tag = "R1";
        wr_ctl(16'h0000);
        step(3'd1, 1'b0, 32'h1, 16'h0, 1'b1, 16'h0002, 1'b0, 16'h0);
        check("R1", "write applies next cycle", 64'(a0_out), 64'h1);
        do_op(3'd1, 1'b0, 32'h1, 16'h0);
        check("R1", "new align in use", 64'(a0_out), 64'h4);

        cur_tag = "R3";
        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            step(3'(r[2:0]), r[3], $urandom, 16'($urandom),
                 (r[7:4] == 4'd0), 16'($urandom), (r[11:8] == 4'd0), 16'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule